// File: doc/BRIEF.md
# Serial Converter Lane Word Deserializer

This block turns one serial converter lane into parallel 14-bit samples. The lane carries two bits per bit-clock period, one latched on each clock edge. Ahead of this block the physical capture stage delivers the lane as two registered streams: the rising-edge bit and the falling-edge bit of each period. It delivers the accompanying frame clock in the same form. The block runs in the bit-clock domain. Seven clock cycles carry one 14-bit word, so a 280 MHz bit clock gives 40 MSa/s at 560 Mb/s.

Word boundaries come from the frame clock alone. The frame clock is high for the first seven bits of each word and low for the last seven. The block treats the sampled frame clock as a bit pattern. It moves its word boundary one bit at a time until the frame's rising edge sits on the first bit of a word.

Lock is handled by a four-state machine:

| State | Meaning |
|---|---|
| SEARCH | Alignment not yet found. |
| CONFIRM | Counting correct frames before declaring lock. |
| LOCKED | Aligned and emitting words. |
| HOLD | Aligned, but the last frame was misaligned. |

The transitions happen only at the end of a word:

| From | To | Condition |
|---|---|---|
| SEARCH | SEARCH | Misaligned frame; the boundary slips one bit. |
| SEARCH | CONFIRM | Correct frame. |
| CONFIRM | CONFIRM | Correct frame; the count grows. |
| CONFIRM | LOCKED | The fourth consecutive correct frame. |
| CONFIRM | SEARCH | Misaligned frame; the boundary slips one bit. |
| LOCKED | HOLD | Misaligned frame. |
| HOLD | LOCKED | Correct frame. |
| HOLD | SEARCH | Second consecutive misaligned frame. |

A separate monitor measures the distance between successive frame rising edges. It flags any distance other than 14 bits.

Top module: `adc_frame_deser`

## Requirements
- R1: While locked, `word_vld` pulses for exactly one cycle every 7 clock cycles, one pulse per completed 14-bit word.
- R2: Bit order is fixed. In each cycle the `dat_rise` bit precedes the `dat_fall` bit, and the first bit of a word lands in `word_o[13]`, the most significant bit.
- R3: A word begins on the bit where the sampled frame clock goes from 0 to 1. Alignment is reached by single-bit slips for every one of the 14 possible bit offsets of the frame edge relative to the clock cycle.
- R4: `locked` rises only after 4 consecutive correctly aligned frames. At an unchanged alignment, regaining lock after a drop takes exactly 28 cycles.
- R5: A single misaligned frame while locked does not clear `locked`, and the delivered word sequence continues without a gap.
- R6: Two consecutive misaligned frames clear `locked`, and the alignment search restarts.
- R7: `word_vld` is never high while `locked` is low.
- R8: `frame_err` pulses when two successive frame rising edges are not 14 bits apart. It stays low for a frame clock with correct spacing, and the first edge after reset never raises it.
- R9: A synchronous reset clears the shift register and lock state, drives `locked`, `word_vld` and `frame_err` low on the next cycle, and forces a new alignment search.
- R10: With a clean lane after reset is released, `locked` is high within 160 clock cycles for any bit offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-clock domain clock, one cycle per two lane bits |
| rst | input | 1 | Synchronous active-high reset |
| dat_rise | input | 1 | Lane bit captured on the rising bit-clock edge |
| dat_fall | input | 1 | Lane bit captured on the following falling edge |
| frm_rise | input | 1 | Frame clock sampled on the rising bit-clock edge |
| frm_fall | input | 1 | Frame clock sampled on the following falling edge |
| word_o | output | 14 | Recovered sample word, most significant bit first in time |
| word_vld | output | 1 | One-cycle strobe for each new word while locked |
| locked | output | 1 | High in LOCKED and HOLD |
| frame_err | output | 1 | One-cycle pulse on a frame edge at the wrong spacing |

## Verification
A wrong boundary phase or slip step appears at the ports within one frame. Either `locked` never rises, or the first words delivered fail to match any transmitted word in order.

A miscounted confirm or miss counter changes how long `locked` stays low after two bad frames, which the bench times to the cycle against 28. A wrong single-miss rule shows up as a lock drop.

A wrong edge-distance counter raises `frame_err` within 14 bits of the next frame edge on a clean lane. Missing that error shows up when a frame edge is suppressed.

// File: rtl/adc_deser_pkg.sv
package adc_deser_pkg;
    typedef enum logic [1:0] {
        ST_SEARCH  = 2'd0,
        ST_CONFIRM = 2'd1,
        ST_LOCKED  = 2'd2,
        ST_HOLD    = 2'd3
    } lock_state_t;
endpackage

// File: rtl/ddr_lane_shift.sv
// Shifts two lane bits and two frame samples per cycle and presents the
// word window selected by the boundary phase.
module ddr_lane_shift #(
    parameter int WORD_W = 14
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              d_rise,
    input  logic              d_fall,
    input  logic              f_rise,
    input  logic              f_fall,
    input  logic              phase,
    output logic [WORD_W-1:0] word,
    output logic              frm_ok
);
    localparam int HALF = WORD_W / 2;
    localparam int DW   = WORD_W + 1;
    localparam int FW   = WORD_W + 2;
    localparam logic [WORD_W:0] FRAME_PAT = {1'b0, {HALF{1'b1}}, {HALF{1'b0}}};

    logic [DW-1:0]     dsr;
    logic [FW-1:0]     fsr;
    logic [WORD_W:0]   fwin;

    always_ff @(posedge clk) begin
        if (rst) begin
            dsr <= '0;
            fsr <= '0;
        end else begin
            dsr <= {dsr[DW-3:0], d_rise, d_fall};
            fsr <= {fsr[FW-3:0], f_rise, f_fall};
        end
    end

    always_comb begin
        word   = phase ? dsr[WORD_W:1] : dsr[WORD_W-1:0];
        fwin   = phase ? fsr[WORD_W+1:1] : fsr[WORD_W:0];
        frm_ok = (fwin == FRAME_PAT);
    end

    assert_clear_R9: assert property (@(posedge clk)
        rst |=> (dsr == '0 && fsr == '0));
endmodule

// File: rtl/frame_timer.sv
// Word boundary timer; a slip moves the boundary one bit later.
module frame_timer #(
    parameter int FRAME_CYC = 7
) (
    input  logic clk,
    input  logic rst,
    input  logic slip,
    output logic tick,
    output logic phase
);
    localparam int CW = $clog2(FRAME_CYC + 1);
    localparam logic [CW-1:0] LAST    = CW'(FRAME_CYC - 1);
    localparam logic [CW-1:0] STRETCH = CW'(FRAME_CYC);

    logic [CW-1:0] cnt;

    assign tick = (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= LAST;
            phase <= 1'b0;
        end else if (tick) begin
            if (slip && !phase) begin
                cnt   <= STRETCH;
                phase <= 1'b1;
            end else if (slip) begin
                cnt   <= LAST;
                phase <= 1'b0;
            end else begin
                cnt   <= LAST;
            end
        end else begin
            cnt <= cnt - 1'b1;
        end
    end

    assert_slip_on_tick_R3: assert property (@(posedge clk) disable iff (rst)
        slip |-> tick);
endmodule

// File: rtl/edge_spacing_mon.sv
// Measures the bit distance between frame rising edges.
module edge_spacing_mon #(
    parameter int WORD_W = 14
) (
    input  logic clk,
    input  logic rst,
    input  logic f_rise,
    input  logic f_fall,
    output logic err
);
    localparam int GW = $clog2(4 * WORD_W);
    localparam int SW = GW + 1;
    localparam logic [GW-1:0] GMAX = '1;

    logic          prev_f;
    logic          seen;
    logic [GW-1:0] gap;
    logic [SW-1:0] spacing;
    logic          edge_r;
    logic          edge_f;

    always_comb begin
        edge_r  = f_rise & ~prev_f;
        edge_f  = f_fall & ~f_rise;
        spacing = edge_r ? ({1'b0, gap} + SW'(1)) : ({1'b0, gap} + SW'(2));
    end

    always_ff @(posedge clk) begin
        prev_f <= f_fall;
        if (rst) begin
            seen <= 1'b0;
            gap  <= '0;
            err  <= 1'b0;
        end else begin
            err <= (edge_r | edge_f) & seen & (spacing != SW'(WORD_W));
            if (edge_r) begin
                gap  <= GW'(1);
                seen <= 1'b1;
            end else if (edge_f) begin
                gap  <= '0;
                seen <= 1'b1;
            end else if (gap > GW'((1 << GW) - 3)) begin
                gap <= GMAX;
            end else begin
                gap <= gap + GW'(2);
            end
        end
    end
endmodule

// File: rtl/lock_fsm.sv
// Alignment search and lock supervision.
module lock_fsm
    import adc_deser_pkg::*;
#(
    parameter int LOCK_FRAMES   = 4,
    parameter int UNLOCK_FRAMES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic good,
    output logic slip,
    output logic emit,
    output logic locked
);
    localparam int HW = $clog2(LOCK_FRAMES + 1);
    localparam int MW = $clog2(UNLOCK_FRAMES + 1);

    lock_state_t   state_q, state_d;
    logic [HW-1:0] hit_q, hit_d;
    logic [MW-1:0] miss_q, miss_d;

    always_comb begin
        state_d = state_q;
        hit_d   = hit_q;
        miss_d  = miss_q;
        if (tick) begin
            unique case (state_q)
                ST_SEARCH: begin
                    if (good) begin
                        if (LOCK_FRAMES <= 1) begin
                            state_d = ST_LOCKED;
                        end else begin
                            state_d = ST_CONFIRM;
                            hit_d   = HW'(1);
                        end
                    end
                end
                ST_CONFIRM: begin
                    if (!good)
                        state_d = ST_SEARCH;
                    else if (hit_q == HW'(LOCK_FRAMES - 1))
                        state_d = ST_LOCKED;
                    else
                        hit_d = hit_q + 1'b1;
                end
                ST_LOCKED: begin
                    if (!good) begin
                        if (UNLOCK_FRAMES <= 1) begin
                            state_d = ST_SEARCH;
                        end else begin
                            state_d = ST_HOLD;
                            miss_d  = MW'(1);
                        end
                    end
                end
                ST_HOLD: begin
                    if (good)
                        state_d = ST_LOCKED;
                    else if (miss_q == MW'(UNLOCK_FRAMES - 1))
                        state_d = ST_SEARCH;
                    else
                        miss_d = miss_q + 1'b1;
                end
                default: state_d = ST_SEARCH;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_SEARCH;
            hit_q   <= '0;
            miss_q  <= '0;
        end else begin
            state_q <= state_d;
            hit_q   <= hit_d;
            miss_q  <= miss_d;
        end
    end

    always_comb begin
        locked = (state_q == ST_LOCKED) || (state_q == ST_HOLD);
        slip   = tick && !good &&
                 ((state_q == ST_SEARCH) || (state_q == ST_CONFIRM));
        emit   = tick && locked && (state_d != ST_SEARCH);
    end

    assert_drop_to_search_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(locked) |-> (state_q == ST_SEARCH));

    assert_lock_after_confirm_R4: assert property (@(posedge clk) disable iff (rst)
        ($rose(locked) && (LOCK_FRAMES > 1)) |-> ($past(state_q) == ST_CONFIRM));
endmodule

// File: rtl/adc_frame_deser.sv
module adc_frame_deser #(
    parameter int WORD_W        = 14,
    parameter int LOCK_FRAMES   = 4,
    parameter int UNLOCK_FRAMES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dat_rise,
    input  logic              dat_fall,
    input  logic              frm_rise,
    input  logic              frm_fall,
    output logic [WORD_W-1:0] word_o,
    output logic              word_vld,
    output logic              locked,
    output logic              frame_err
);
    localparam int FRAME_CYC = WORD_W / 2;

    logic              phase;
    logic              tick;
    logic              slip;
    logic              emit;
    logic              good;
    logic [WORD_W-1:0] word;

    ddr_lane_shift #(.WORD_W(WORD_W)) u_shift (
        .clk    (clk),
        .rst    (rst),
        .d_rise (dat_rise),
        .d_fall (dat_fall),
        .f_rise (frm_rise),
        .f_fall (frm_fall),
        .phase  (phase),
        .word   (word),
        .frm_ok (good)
    );

    frame_timer #(.FRAME_CYC(FRAME_CYC)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .slip  (slip),
        .tick  (tick),
        .phase (phase)
    );

    lock_fsm #(
        .LOCK_FRAMES   (LOCK_FRAMES),
        .UNLOCK_FRAMES (UNLOCK_FRAMES)
    ) u_fsm (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .good   (good),
        .slip   (slip),
        .emit   (emit),
        .locked (locked)
    );

    edge_spacing_mon #(.WORD_W(WORD_W)) u_mon (
        .clk    (clk),
        .rst    (rst),
        .f_rise (frm_rise),
        .f_fall (frm_fall),
        .err    (frame_err)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            word_o   <= '0;
            word_vld <= 1'b0;
        end else begin
            word_vld <= emit;
            if (emit)
                word_o <= word;
        end
    end

    assert_valid_locked_R7: assert property (@(posedge clk) disable iff (rst)
        word_vld |-> locked);

    assert_valid_single_R1: assert property (@(posedge clk) disable iff (rst)
        word_vld |=> !word_vld);
endmodule

// File: tb/tb_adc_frame_deser.sv
module tb_adc_frame_deser;
    localparam int WW = 14;
    localparam int FC = 7;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          dat_rise = 1'b0;
    logic          dat_fall = 1'b0;
    logic          frm_rise = 1'b0;
    logic          frm_fall = 1'b0;
    logic [WW-1:0] word_o;
    logic          word_vld;
    logic          locked;
    logic          frame_err;

    adc_frame_deser dut (
        .clk       (clk),
        .rst       (rst),
        .dat_rise  (dat_rise),
        .dat_fall  (dat_fall),
        .frm_rise  (frm_rise),
        .frm_fall  (frm_fall),
        .word_o    (word_o),
        .word_vld  (word_vld),
        .locked    (locked),
        .frame_err (frame_err)
    );

    always #4 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    int cyc    = 0;
    int off    = 0;
    int cor_lo = -10;
    int cor_hi = -10;

    int vld_n, seq_bad, gap_bad, vld_unlocked, err_n;
    int exp_m, last_v, low_run, last_low, low_cnt, lock_at, rel_cyc;
    bit was_locked = 1'b0;

    function automatic logic [WW-1:0] wval(int m);
        return WW'(m * 1237 + 91);
    endfunction

    function automatic logic dbit(int k);
        int j = k + WW - off;
        logic [WW-1:0] w = wval(j / WW);
        return w[WW-1-(j % WW)];
    endfunction

    function automatic logic fbit(int k);
        int j = k + WW - off;
        int m = j / WW;
        return ((j % WW) < FC) && !(m >= cor_lo && m <= cor_hi);
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic clear_stats();
        vld_n = 0; seq_bad = 0; gap_bad = 0; vld_unlocked = 0; err_n = 0;
        exp_m = -1; last_v = -1; low_run = 0; last_low = -1; low_cnt = 0;
        lock_at = -1; rel_cyc = cyc;
    endtask

    task automatic step();
        @(negedge clk);
        if (word_vld) begin
            vld_n++;
            if (!locked) vld_unlocked++;
            if (last_v >= 0 && (cyc - last_v) != FC) gap_bad++;
            last_v = cyc;
            if (exp_m < 0) begin
                bit found = 1'b0;
                for (int m = 0; m <= cyc / FC + 4; m++) begin
                    if (!found && wval(m) == word_o) begin
                        exp_m = m + 1;
                        found = 1'b1;
                    end
                end
                if (!found) seq_bad++;
            end else begin
                if (word_o != wval(exp_m)) seq_bad++;
                exp_m++;
            end
        end
        if (frame_err) err_n++;
        if (locked) begin
            if (!was_locked) begin
                last_low = low_run;
                if (lock_at < 0) lock_at = cyc - rel_cyc;
            end
            low_run = 0;
        end else begin
            low_cnt++;
            if (was_locked) begin
                exp_m   = -1;
                last_v  = -1;
                low_run = 0;
            end
            low_run++;
        end
        was_locked = locked;
        dat_rise = dbit(2 * cyc);
        dat_fall = dbit(2 * cyc + 1);
        frm_rise = fbit(2 * cyc);
        frm_fall = fbit(2 * cyc + 1);
        cyc++;
    endtask

    task automatic t_reset_state();
        off = 0;
        rst = 1'b1;
        clear_stats();
        repeat (4) step();
        check(locked == 1'b0,    "R9", "locked in reset", int'(locked), 0);
        check(word_vld == 1'b0,  "R9", "valid in reset", int'(word_vld), 0);
        check(frame_err == 1'b0, "R9", "error in reset", int'(frame_err), 0);
        rst = 1'b0;
    endtask

    task automatic t_acquire(int o);
        off = o;
        rst = 1'b1;
        repeat (3) step();
        rst = 1'b0;
        clear_stats();
        repeat (300) step();
        check(locked == 1'b1, "R3", $sformatf("locked at offset %0d", o), int'(locked), 1);
        check(lock_at >= 0 && lock_at <= 160, "R10",
              $sformatf("cycles to lock at offset %0d", o), lock_at, 160);
        check(vld_n >= 15 && seq_bad == 0, "R2",
              $sformatf("word order/content mismatches at offset %0d", o), seq_bad, 0);
        check(gap_bad == 0, "R1", $sformatf("valid spacing faults at offset %0d", o), gap_bad, 0);
        check(vld_unlocked == 0, "R7", "valid without lock", vld_unlocked, 0);
        check(err_n == 0, "R8", $sformatf("frame errors on clean lane at offset %0d", o), err_n, 0);
    endtask

    task automatic t_one_bad_frame();
        int m_now = (2 * cyc + WW - off) / WW;
        clear_stats();
        exp_m = -1;
        cor_lo = m_now + 3;
        cor_hi = m_now + 3;
        repeat (70) step();
        cor_lo = -10;
        cor_hi = -10;
        check(low_cnt == 0, "R5", "cycles unlocked after one bad frame", low_cnt, 0);
        check(seq_bad == 0 && gap_bad == 0, "R5", "word stream breaks", seq_bad + gap_bad, 0);
        check(err_n >= 1, "R8", "error pulses for missing edge", err_n, 1);
    endtask

    task automatic t_two_bad_frames();
        int m_now = (2 * cyc + WW - off) / WW;
        clear_stats();
        cor_lo = m_now + 3;
        cor_hi = m_now + 4;
        repeat (120) step();
        cor_lo = -10;
        cor_hi = -10;
        check(low_cnt > 0, "R6", "lock dropped after two bad frames", low_cnt, 28);
        check(last_low == 28, "R4", "cycles to regain lock", last_low, 28);
        check(locked == 1'b1, "R6", "locked after recovery", int'(locked), 1);
        check(err_n >= 1, "R8", "error pulses for missing edges", err_n, 1);
        check(seq_bad == 0 && vld_unlocked == 0, "R7", "bad words or valid while unlocked",
              seq_bad + vld_unlocked, 0);
    endtask

    task automatic t_mid_reset();
        rst = 1'b1;
        step();
        check(locked == 1'b0 && word_vld == 1'b0, "R9", "lock/valid after sync reset",
              int'(locked) + int'(word_vld), 0);
        rst = 1'b0;
        clear_stats();
        repeat (250) step();
        check(locked == 1'b1 && seq_bad == 0, "R9", "reacquire after sync reset",
              int'(locked), 1);
    endtask

    initial begin
        clear_stats();
        t_reset_state();
        t_acquire(0);
        t_acquire(5);
        t_acquire(13);
        t_one_bad_frame();
        t_two_bad_frames();
        t_mid_reset();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            errors++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule